// File: doc/BRIEF.md
# SPI EEPROM Page-Write Controller

This block is the write side of a serial EEPROM behind an SPI slave port. While `spi_cs_n` is low it deserialises, MSB first on rising `spi_sck` edges, an instruction byte, a 16-bit address and then data bytes. The data bytes land in a 32-byte page buffer at a running offset. The offset wraps inside the page, so later bytes replace earlier ones at the same slot. All three SPI lines are brought into the `clk` domain through two-flop synchronisers and edge detectors.

When `spi_cs_n` rises, an acceptance gate decides in one cycle whether the instruction is carried out. The checks are the opcode, the bit alignment, the write-enable latch, a busy write cycle and the block-protect region. An accepted instruction raises `wip` and copies the buffered bytes into the array, one slot per clock. It then waits a fixed number of clocks, after which `wip` falls and the write-enable latch clears. A rejected instruction leaves no trace.

The other instructions are reduced to plain pins: a set strobe for the latch and a one-cycle read port into the array. The SPI side is a serial stream without a handshake. The block can always take the next bit, so there is no back-pressure, and bits that arrive while a write cycle runs are dropped.

Top module: `spi_eeprom_pgwr`

## Requirements
- R1: A write is the opcode 0x02 followed by address byte high, address byte low and data, all sampled MSB first on rising `spi_sck` while `spi_cs_n` is low. Any other opcode leaves memory, `wip` and `wel` unchanged.
- R2: An instruction is carried out only if `spi_cs_n` rises after a whole number of data bytes, with at least one data byte. A rise inside a byte or before the first data byte discards it.
- R3: All data bytes of one selection are committed in a single write cycle.
- R4: After each data byte only the 5-bit in-page offset (address bits 4:0) increments, wrapping from 31 to 0. A later byte overwrites the earlier byte at the same offset.
- R5: Address bits at and above log2(MEM_BYTES) (bit 10 by default) are ignored.
- R6: An instruction is rejected when `wel` is 0 as `spi_cs_n` rises.
- R7: An instruction is rejected if a write cycle was in progress at any time while it was selected.
- R8: `bp` protects part of the array, with `bp` address regions reading top bits of the 10-bit array address: 00 none, 01 address bits [9:8]==11, 10 bit [9]==1, 11 all. A write whose page lies in the region is rejected.
- R9: After an accepted write, `wip` goes high on the third rising `clk` edge after `spi_cs_n` rises. It stays high for exactly PAGE_BYTES+WRITE_CYCLES clocks.
- R10: `wel_set` high at a rising edge sets `wel`. `wel` clears on the edge where `wip` falls, and clearing wins over setting.
- R11: A rejected or discarded instruction changes no memory byte and does not raise `wip`.
- R12: `rd_data` presents the array byte at `rd_addr` one clock after `rd_addr` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sck | input | 1 | SPI serial clock |
| spi_mosi | input | 1 | SPI serial data into the block |
| wel_set | input | 1 | sets the write-enable latch |
| bp | input | 2 | block-protect setting |
| rd_addr | input | log2(MEM_BYTES) | read port address |
| rd_data | output | 8 | registered read data |
| wel | output | 1 | write-enable latch |
| wip | output | 1 | write cycle in progress |

## Verification
Several properties are checked on every cycle by assertions:
- no write cycle starts without `wel` or inside a protected page;
- every `wip` pulse has the exact length;
- `wel` is low when `wip` falls;
- the deserialiser is cleared while deselected;
- buffer slots are never lost outside a clear.

Other behaviours show only through the bench's scenarios against its reference array: which bytes actually reach memory, the offset wrap with overwrite, ignored upper address bits, rejection for a mid-byte rise, a foreign opcode, or a transaction that overlaps a busy cycle.

// File: rtl/eeprom_pw_pkg.sv
package eeprom_pw_pkg;

  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_COMMIT,
    ST_WAIT
  } wr_state_e;

  // top2 = two most significant array address bits of the page
  function automatic logic prot_hit(input logic [1:0] bp, input logic [1:0] top2);
    logic hit;
    case (bp)
      2'b00:   hit = 1'b0;
      2'b01:   hit = (top2 == 2'b11);
      2'b10:   hit = top2[1];
      default: hit = 1'b1;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/eeprom_pw_sync.sv
module eeprom_pw_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= RST_VAL;
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/eeprom_pw_deser.sv
module eeprom_pw_deser (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       sck_rise,
  input  logic       din,
  output logic       byte_stb,
  output logic [7:0] byte_q,
  output logic [2:0] stb_idx,
  output logic       aligned,
  output logic       data_seen
);
  logic [2:0] bit_cnt;
  logic [6:0] sh;
  logic [2:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      sh       <= '0;
      cnt      <= '0;
      byte_stb <= 1'b0;
      byte_q   <= '0;
      stb_idx  <= '0;
    end else if (!sel) begin
      bit_cnt  <= '0;
      cnt      <= '0;
      byte_stb <= 1'b0;
    end else begin
      byte_stb <= 1'b0;
      if (sck_rise) begin
        bit_cnt <= bit_cnt + 3'd1;
        sh      <= {sh[5:0], din};
        if (bit_cnt == 3'd7) begin
          byte_stb <= 1'b1;
          byte_q   <= {sh, din};
          stb_idx  <= cnt;
          if (cnt != 3'd4) cnt <= cnt + 3'd1;
        end
      end
    end
  end

  assign aligned   = (bit_cnt == 3'd0);
  assign data_seen = (cnt == 3'd4);

  // R2: deselection returns the bit counter to a byte boundary
  a_r2_clear_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (bit_cnt == 3'd0) && !byte_stb);
endmodule

// File: rtl/eeprom_pw_pagebuf.sv
module eeprom_pw_pagebuf #(
  parameter int DEPTH = 32,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [7:0]    wdata,
  input  logic [IW-1:0] ridx,
  output logic [7:0]    rdata,
  output logic          rvalid
);
  logic [7:0]       slot [DEPTH];
  logic [DEPTH-1:0] mask;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask[g] <= 1'b0;
        slot[g] <= '0;
      end else if (clr) begin
        mask[g] <= 1'b0;
      end else if (we && widx == IW'(g)) begin
        mask[g] <= 1'b1;
        slot[g] <= wdata;
      end
    end
  end

  assign rdata  = slot[ridx];
  assign rvalid = mask[ridx];

  // R4: a filled slot stays filled until the buffer is cleared
  a_r4_mask_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (($past(mask) & ~mask) == '0));
endmodule

// File: rtl/spi_eeprom_pgwr.sv
module spi_eeprom_pgwr #(
  parameter int MEM_BYTES    = 1024,
  parameter int PAGE_BYTES   = 32,
  parameter int WRITE_CYCLES = 5000,
  localparam int AW  = $clog2(MEM_BYTES),
  localparam int PW  = $clog2(PAGE_BYTES),
  localparam int PGW = AW - PW,
  localparam int CW  = $clog2(WRITE_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_cs_n,
  input  logic          spi_sck,
  input  logic          spi_mosi,
  input  logic          wel_set,
  input  logic [1:0]    bp,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          wel,
  output logic          wip
);
  import eeprom_pw_pkg::*;

  // ---------------- input synchronisation and edges
  logic cs_s, sck_s, mosi_s, cs_d, sck_d;

  eeprom_pw_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_cs_n, spi_sck, spi_mosi}),
    .q({cs_s, sck_s, mosi_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d  <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      cs_d  <= cs_s;
      sck_d <= sck_s;
    end
  end

  logic sel, sck_rise, cs_rise;
  assign sel      = !cs_s;
  assign sck_rise = sck_s && !sck_d;
  assign cs_rise  = cs_s && !cs_d;

  // ---------------- deserialiser
  logic       byte_stb, aligned, data_seen;
  logic [7:0] byte_q;
  logic [2:0] stb_idx;

  eeprom_pw_deser u_deser (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sck_rise(sck_rise), .din(mosi_s),
    .byte_stb(byte_stb), .byte_q(byte_q), .stb_idx(stb_idx),
    .aligned(aligned), .data_seen(data_seen)
  );

  // ---------------- header capture and page offset
  wr_state_e      state;
  logic [7:0]     opcode_q;
  logic [PGW-1:0] page_q;
  logic [PW-1:0]  offset_q;
  logic           blocked;
  logic           idle;

  assign idle = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opcode_q <= '0;
      page_q   <= '0;
      offset_q <= '0;
    end else if (byte_stb && idle && !blocked) begin
      case (stb_idx)
        3'd0: opcode_q <= byte_q;
        3'd1: page_q[PGW-1 -: AW-8] <= byte_q[AW-9:0];
        3'd2: begin
          page_q[8-PW-1:0] <= byte_q[7:PW];
          offset_q         <= byte_q[PW-1:0];
        end
        default: offset_q <= offset_q + PW'(1);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       blocked <= 1'b0;
    else if (!sel)    blocked <= 1'b0;
    else if (!idle)   blocked <= 1'b1;
  end

  // ---------------- page buffer
  logic          buf_clr, buf_we, buf_valid;
  logic [7:0]    buf_data;
  logic [PW-1:0] commit_idx;

  assign buf_clr = !sel && idle && !cs_rise;
  assign buf_we  = byte_stb && (stb_idx >= 3'd3) && idle && !blocked;

  eeprom_pw_pagebuf #(.DEPTH(PAGE_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr),
    .we(buf_we), .widx(offset_q), .wdata(byte_q),
    .ridx(commit_idx), .rdata(buf_data), .rvalid(buf_valid)
  );

  // ---------------- acceptance gate and write sequencer
  logic          go;
  logic [CW-1:0] wcnt;
  logic          done;

  assign go = idle && cs_rise && (opcode_q == OP_WRITE) && aligned && data_seen
              && wel && !blocked && !prot_hit(bp, page_q[PGW-1 -: 2]);
  assign done = (state == ST_WAIT) && (wcnt == CW'(WRITE_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      commit_idx <= '0;
      wcnt       <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          commit_idx <= '0;
          if (go) state <= ST_COMMIT;
        end
        ST_COMMIT: begin
          commit_idx <= commit_idx + PW'(1);
          if (commit_idx == PW'(PAGE_BYTES - 1)) begin
            state <= ST_WAIT;
            wcnt  <= '0;
          end
        end
        ST_WAIT: begin
          wcnt <= wcnt + CW'(1);
          if (done) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign wip = !idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wel <= 1'b0;
    else if (done)    wel <= 1'b0;
    else if (wel_set) wel <= 1'b1;
  end

  // ---------------- memory array
  logic [7:0] mem [MEM_BYTES];
  logic       mem_we;
  assign mem_we = (state == ST_COMMIT) && buf_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= '0;
      rd_data <= '0;
    end else begin
      if (mem_we) mem[{page_q, commit_idx}] <= buf_data;
      rd_data <= mem[rd_addr];
    end
  end

  // ---------------- assertions
  int wip_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   wip_len <= 0;
    else if (wip) wip_len <= wip_len + 1;
    else          wip_len <= 0;
  end

  // R6: a write cycle only starts with the latch set
  a_r6_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(wel));
  // R8: a write cycle never starts for a protected page
  a_r8_not_protected: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> !prot_hit($past(bp), page_q[PGW-1 -: 2]));
  // R9: busy pulse has the exact length
  a_r9_wip_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> (wip_len == PAGE_BYTES + WRITE_CYCLES));
  // R10: latch is clear when the cycle ends
  a_r10_wel_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> !wel);
endmodule

// File: tb/spi_eeprom_pgwr_test.sv
module spi_eeprom_pgwr_test;
  localparam int MEMB = 1024;
  localparam int PAGE = 32;
  localparam int WC   = 600;

  logic clk = 0;
  logic rst_n = 0;
  logic cs_n = 1, sck = 0, mosi = 0, wel_set = 0;
  logic [1:0] bp = 2'b00;
  logic [9:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic wel, wip;

  always #2 clk = ~clk;

  spi_eeprom_pgwr #(.MEM_BYTES(MEMB), .PAGE_BYTES(PAGE), .WRITE_CYCLES(WC)) uut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .wel_set(wel_set), .bp(bp), .rd_addr(rd_addr), .rd_data(rd_data),
    .wel(wel), .wip(wip)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] mem_m [MEMB];
  int start_cnt = 0, busy_m = 0;
  logic wel_m = 0;
  bit run = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference timing of wip / wel
  always @(posedge clk) begin
    if (run) begin
      if (start_cnt > 0) begin
        start_cnt--;
        if (start_cnt == 0) busy_m = PAGE + WC;
        if (wel_set) wel_m = 1;
      end else if (busy_m > 0) begin
        busy_m--;
        if (busy_m == 0) wel_m = 0;
        else if (wel_set) wel_m = 1;
      end else if (wel_set) wel_m = 1;
    end
  end

  // compare on every clock
  always @(negedge clk) begin
    if (run) begin
      check(wip == (busy_m > 0), "R9 wip", wip, busy_m > 0);
      check(wel == wel_m, "R10 wel", wel, wel_m);
    end
  end

  task automatic pulse_wel();
    @(negedge clk) wel_set = 1;
    @(negedge clk) wel_set = 0;
  endtask

  task automatic sbit(input logic b);
    @(negedge clk) begin mosi = b; sck = 0; end
    repeat (4) @(negedge clk);
    sck = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic sbyte(input logic [7:0] v, input int nb);
    for (int i = 7; i > 7 - nb; i--) sbit(v[i]);
  endtask

  function automatic logic prot_m(input logic [1:0] b, input logic [9:0] a);
    case (b)
      2'b00: return 1'b0;
      2'b01: return a[9:8] == 2'b11;
      2'b10: return a[9];
      default: return 1'b1;
    endcase
  endfunction

  // one selection: opcode, address, n data bytes, then extra stray bits
  task automatic spi_tx(input logic [7:0] op, input logic [15:0] a, input int n,
                        input logic [7:0] base, input int extra);
    bit blk;
    bit acc;
    logic [4:0] off;
    blk = (busy_m > 0) || (start_cnt > 0);
    @(negedge clk) cs_n = 0;
    repeat (4) @(negedge clk);
    sbyte(op, 8);
    sbyte(a[15:8], 8);
    sbyte(a[7:0], 8);
    for (int k = 0; k < n; k++) sbyte(base + 8'(k * 7), 8);
    if (extra > 0) sbyte(8'h5A, extra);
    @(negedge clk) sck = 0;
    repeat (4) @(negedge clk);
    blk = blk || (busy_m > 0) || (start_cnt > 0);
    acc = (op == 8'h02) && (extra == 0) && (n >= 1) && wel_m && !blk
          && !prot_m(bp, a[9:0]);
    cs_n = 1;
    if (acc) begin
      start_cnt = 3;
      off = a[4:0];
      for (int k = 0; k < n; k++) begin
        mem_m[{a[9:5], off}] = base + 8'(k * 7);
        off = off + 5'd1;
      end
    end
  endtask

  task automatic wait_idle();
    while (busy_m > 0 || start_cnt > 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic read_page(input logic [9:0] a, input string req);
    for (int i = 0; i < PAGE; i++) begin
      @(negedge clk) rd_addr = {a[9:5], 5'(i)};
      @(negedge clk);
      check(rd_data == mem_m[{a[9:5], 5'(i)}], req, rd_data, mem_m[{a[9:5], 5'(i)}]);
    end
  endtask

  bit fin = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < MEMB; i++) mem_m[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    run = 1;
    @(negedge clk);
    // reset state, R12 read port
    check(wip == 0, "R9 reset wip", wip, 0);
    check(wel == 0, "R10 reset wel", wel, 0);
    check(rd_data == 0, "R12 reset rd_data", rd_data, 0);

    // R6: no latch, rejected (R11)
    spi_tx(8'h02, 16'h0010, 1, 8'hA5, 0);
    wait_idle(); read_page(10'h010, "R6 R11 no wel");

    // R1 R2: single byte
    pulse_wel();
    spi_tx(8'h02, 16'h0010, 1, 8'hA5, 0);
    wait_idle(); read_page(10'h010, "R1 R2 single byte");

    // R3: several bytes in one cycle
    pulse_wel();
    spi_tx(8'h02, 16'h0044, 5, 8'h31, 0);
    wait_idle(); read_page(10'h040, "R3 multi byte");

    // R4: wrap with overwrite
    pulse_wel();
    spi_tx(8'h02, 16'h007C, 36, 8'h10, 0);
    wait_idle(); read_page(10'h060, "R4 wrap");

    // R5: upper address bits ignored
    pulse_wel();
    spi_tx(8'h02, 16'hFC20, 2, 8'hC3, 0);
    wait_idle(); read_page(10'h020, "R5 upper bits");

    // R2 R11: rise inside a byte, and no data byte
    pulse_wel();
    spi_tx(8'h02, 16'h0100, 1, 8'h77, 3);
    wait_idle(); read_page(10'h100, "R2 R11 mid-byte");
    spi_tx(8'h02, 16'h0100, 0, 8'h77, 0);
    wait_idle(); read_page(10'h100, "R2 R11 header only");

    // R1: foreign opcode
    spi_tx(8'h03, 16'h0100, 2, 8'h88, 0);
    wait_idle(); read_page(10'h100, "R1 other opcode");
    spi_tx(8'h02, 16'h0100, 1, 8'h99, 0);
    wait_idle(); read_page(10'h100, "R1 write after foreign");

    // R8: protection
    bp = 2'b01; pulse_wel();
    spi_tx(8'h02, 16'h0300, 1, 8'h41, 0);
    wait_idle(); read_page(10'h300, "R8 bp01 upper quarter");
    spi_tx(8'h02, 16'h0200, 1, 8'h42, 0);
    wait_idle(); read_page(10'h200, "R8 bp01 allowed");
    bp = 2'b10; pulse_wel();
    spi_tx(8'h02, 16'h0220, 1, 8'h43, 0);
    wait_idle(); read_page(10'h220, "R8 bp10 upper half");
    bp = 2'b11;
    spi_tx(8'h02, 16'h0000, 1, 8'h44, 0);
    wait_idle(); read_page(10'h000, "R8 bp11 all");
    bp = 2'b00;

    // R7: selection during a busy cycle
    spi_tx(8'h02, 16'h0180, 1, 8'h51, 0);
    pulse_wel();
    spi_tx(8'h02, 16'h01A0, 1, 8'h52, 0);
    wait_idle();
    read_page(10'h180, "R7 first write");
    read_page(10'h1A0, "R7 busy reject");

    fin = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule